// File: doc/BRIEF.md
# Radix-4 Signed-Digit to Two's Complement Converter

This block turns a radix-4 signed-digit number, as produced by a carry-free signed-digit adder, into an ordinary two's complement integer. The number arrives as `NUM_DIGITS` packed 3-bit digit fields plus a 2-bit signed carry digit. Each digit holds a value from -3 to +3 and is weighted by a power of four. The carry digit is worth plus or minus 4^NUM_DIGITS.

A caller presents the fields with `in_valid` high for one cycle. The block captures them on that rising edge and forms the weighted sum in the following cycle. It then raises `out_valid` for one cycle and holds the result. Any field code outside the legal digit set raises `out_bad` together with the result. The result width `RES_W` must be at least 2*NUM_DIGITS+3, and elaboration stops with an error for a smaller width.

Top module: `sd4_to_bin`

## Requirements
- R1: Digit i occupies bits [3*i+2:3*i] of `in_digits`, digit 0 least significant. Each field is read as 3-bit two's complement, sign-extended and multiplied by 4^i, and `out_value` is the sum of all weighted digits plus the carry term.
- R2: The carry code 2'b01 adds 4^NUM_DIGITS, the code 2'b11 subtracts 4^NUM_DIGITS, and 2'b00 adds nothing. For the default of 4 digits this is +256, -256 or 0.
- R3: `out_bad` is 1 with a result when any digit field of that conversion is 3'b100 or the carry field is 2'b10, and 0 otherwise. Such fields still contribute their plain two's complement value: -4 times the digit weight, or -2 times 4^NUM_DIGITS for the carry.
- R4: After the rising edge that samples `in_valid` high, `out_valid` is 1 after the next rising edge, for exactly one cycle unless another conversion follows.
- R5: While no conversion completes, `out_value` and `out_bad` keep their last values whatever `in_digits` and `in_carry` do while `in_valid` is low.
- R6: An active-low reset clears `out_value`, `out_valid` and `out_bad` to 0, and it takes effect without waiting for a clock edge.
- R7: Conversions started on consecutive cycles each produce their own correct result, with `out_valid` high on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| in_valid | input | 1 | Start of a conversion; the fields are sampled when this is high |
| in_digits | input | 3*NUM_DIGITS | Packed signed digits, digit 0 in the low bits |
| in_carry | input | 2 | Signed carry digit worth 4^NUM_DIGITS |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_value | output | RES_W | Two's complement result |
| out_bad | output | 1 | An illegal field code was seen in this conversion |

## Verification
A conversion is launched with `in_valid` high for one edge. Its result, flag and `out_valid` are due after the second rising edge from that point, so the bench samples them at the falling edge that follows. At the next falling edge it checks that `out_valid` has dropped and that value and flag have not changed, after scrambling the fields with `in_valid` low. A 2-digit build is swept over every digit and carry code. The 4-digit build gets directed extremes and seeded random fields, and two back-to-back conversions are checked on successive falling edges. The reset is checked one time unit after it is asserted, with no clock edge in between.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int DIGIT_W = 3;
  localparam int CARRY_W = 2;

  // A digit field may only hold -3..+3; the pattern for -4 is outside the set.
  function automatic logic digit_is_bad(input logic [DIGIT_W-1:0] code);
    return (code == 3'b100);
  endfunction

  // A carry field may only hold -1..+1; the pattern for -2 is outside the set.
  function automatic logic carry_is_bad(input logic [CARRY_W-1:0] code);
    return (code == 2'b10);
  endfunction
endpackage

// File: rtl/sdc_digit_weigh.sv
module sdc_digit_weigh
  import sdc_pkg::*;
#(
  parameter int RES_W = 32,
  parameter int IDX   = 0
) (
  input  logic [DIGIT_W-1:0]     code,
  output logic signed [RES_W-1:0] term,
  output logic                    bad
);
  localparam int SHIFT = 2 * IDX;

  logic signed [RES_W-1:0] ext;

  always_comb begin
    ext  = {{(RES_W-DIGIT_W){code[DIGIT_W-1]}}, code};
    term = ext <<< SHIFT;
    bad  = digit_is_bad(code);
  end
endmodule

// File: rtl/sdc_carry_weigh.sv
module sdc_carry_weigh
  import sdc_pkg::*;
#(
  parameter int RES_W      = 32,
  parameter int NUM_DIGITS = 4
) (
  input  logic [CARRY_W-1:0]      code,
  output logic signed [RES_W-1:0] term,
  output logic                    bad
);
  localparam int SHIFT = 2 * NUM_DIGITS;

  logic signed [RES_W-1:0] ext;

  always_comb begin
    ext  = {{(RES_W-CARRY_W){code[CARRY_W-1]}}, code};
    term = ext <<< SHIFT;
    bad  = carry_is_bad(code);
  end
endmodule

// File: rtl/sdc_sum.sv
module sdc_sum #(
  parameter int RES_W = 32,
  parameter int TERMS = 5
) (
  input  logic [TERMS*RES_W-1:0]  terms,
  output logic signed [RES_W-1:0] total
);
  always_comb begin
    total = '0;
    for (int i = 0; i < TERMS; i++) begin
      total = total + $signed(terms[i*RES_W +: RES_W]);
    end
  end
endmodule

// File: rtl/sd4_to_bin.sv
module sd4_to_bin
  import sdc_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int RES_W      = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [DIGIT_W*NUM_DIGITS-1:0] in_digits,
  input  logic [CARRY_W-1:0]          in_carry,
  output logic                        out_valid,
  output logic signed [RES_W-1:0]     out_value,
  output logic                        out_bad
);
  localparam int IN_W  = DIGIT_W * NUM_DIGITS;
  localparam int TERMS = NUM_DIGITS + 1;
  localparam int MIN_W = 2 * NUM_DIGITS + 3;

  if (RES_W < MIN_W) begin : g_width_guard
    $error("sd4_to_bin: RES_W is too narrow for NUM_DIGITS");
  end

  // Capture stage
  logic              s1_valid, s1_valid_nx;
  logic [IN_W-1:0]   s1_digits, s1_digits_nx;
  logic [CARRY_W-1:0] s1_carry, s1_carry_nx;

  always_comb begin
    s1_valid_nx  = in_valid;
    s1_digits_nx = s1_digits;
    s1_carry_nx  = s1_carry;
    if (in_valid) begin
      s1_digits_nx = in_digits;
      s1_carry_nx  = in_carry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_digits <= '0;
      s1_carry  <= '0;
    end else begin
      s1_valid  <= s1_valid_nx;
      s1_digits <= s1_digits_nx;
      s1_carry  <= s1_carry_nx;
    end
  end

  // Weighting and summation
  logic [TERMS*RES_W-1:0] term_bus;
  logic [TERMS-1:0]       bad_vec;
  logic signed [RES_W-1:0] sum_w;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    logic signed [RES_W-1:0] term_g;
    sdc_digit_weigh #(.RES_W(RES_W), .IDX(g)) u_weigh (
      .code (s1_digits[g*DIGIT_W +: DIGIT_W]),
      .term (term_g),
      .bad  (bad_vec[g])
    );
    assign term_bus[g*RES_W +: RES_W] = term_g;
  end

  logic signed [RES_W-1:0] carry_term;
  sdc_carry_weigh #(.RES_W(RES_W), .NUM_DIGITS(NUM_DIGITS)) u_carry (
    .code (s1_carry),
    .term (carry_term),
    .bad  (bad_vec[NUM_DIGITS])
  );
  assign term_bus[NUM_DIGITS*RES_W +: RES_W] = carry_term;

  sdc_sum #(.RES_W(RES_W), .TERMS(TERMS)) u_sum (
    .terms (term_bus),
    .total (sum_w)
  );

  // Result stage
  logic                    out_valid_nx, out_bad_nx;
  logic signed [RES_W-1:0] out_value_nx;

  always_comb begin
    out_valid_nx = s1_valid;
    out_value_nx = out_value;
    out_bad_nx   = out_bad;
    if (s1_valid) begin
      out_value_nx = sum_w;
      out_bad_nx   = |bad_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
      out_bad   <= 1'b0;
    end else begin
      out_valid <= out_valid_nx;
      out_value <= out_value_nx;
      out_bad   <= out_bad_nx;
    end
  end
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
  parameter int NUM_DIGITS = 4,
  parameter int RES_W      = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [3*NUM_DIGITS-1:0]  in_digits,
  input logic [1:0]               in_carry,
  input logic                     s1_valid,
  input logic                     out_valid,
  input logic signed [RES_W-1:0]  out_value,
  input logic                     out_bad
);
  localparam logic signed [RES_W-1:0] CARRY_ONE = RES_W'(1) <<< (2 * NUM_DIGITS);

  // R4
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  // R4
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s1_valid));

  // R5
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> ($stable(out_value) && $stable(out_bad)));

  // R3
  bad_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_carry == 2'b10) |-> ##2 out_bad);

  // R2
  carry_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_digits == '0 && in_carry == 2'b01) |-> ##2 (out_value == CARRY_ONE));
endmodule

bind sd4_to_bin sdc_checker #(.NUM_DIGITS(NUM_DIGITS), .RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_digits (in_digits),
  .in_carry  (in_carry),
  .s1_valid  (s1_valid),
  .out_valid (out_valid),
  .out_value (out_value),
  .out_bad   (out_bad)
);

// File: tb/sim_sd4_to_bin.sv
`timescale 1ns/1ps
module sim_sd4_to_bin;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        v4 = 1'b0;
  logic [11:0] d4 = '0;
  logic [1:0]  c4 = '0;
  logic        ov4, ob4;
  logic signed [31:0] val4;

  logic        v2 = 1'b0;
  logic [5:0]  d2 = '0;
  logic [1:0]  c2 = '0;
  logic        ov2, ob2;
  logic signed [7:0] val2;

  sd4_to_bin #(.NUM_DIGITS(4), .RES_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v4), .in_digits(d4), .in_carry(c4),
    .out_valid(ov4), .out_value(val4), .out_bad(ob4));

  sd4_to_bin #(.NUM_DIGITS(2), .RES_W(8)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_digits(d2), .in_carry(c2),
    .out_valid(ov2), .out_value(val2), .out_bad(ob2));

  int n_cmp = 0;
  int n_mis = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_val(input logic [11:0] d, input logic [1:0] c, input int n);
    longint acc = 0;
    for (int i = 0; i < n; i++) begin
      longint dv = longint'(d[3*i +: 3]);
      if (d[3*i+2]) dv = dv - 8;
      acc += dv <<< (2*i);
    end
    begin
      longint cv = longint'(c);
      if (c[1]) cv = cv - 4;
      acc += cv <<< (2*n);
    end
    return acc;
  endfunction

  function automatic bit ref_bad(input logic [11:0] d, input logic [1:0] c, input int n);
    bit b = (c == 2'b10);
    for (int i = 0; i < n; i++) if (d[3*i +: 3] == 3'b100) b = 1'b1;
    return b;
  endfunction

  function automatic string val_tag(input logic [11:0] d, input logic [1:0] c, input int n);
    if (ref_bad(d, c, n)) return "R3";
    if (c != 2'b00) return "R2";
    return "R1";
  endfunction

  task automatic run4(input logic [11:0] d, input logic [1:0] c);
    longint exp;
    logic signed [31:0] keep;
    logic kb;
    @(negedge clk); d4 = d; c4 = c; v4 = 1'b1;
    @(negedge clk); v4 = 1'b0;
    @(negedge clk);
    exp = ref_val(d, c, 4);
    check(ov4 == 1'b1, "R4", longint'(ov4), 1);
    check(longint'(val4) == exp, val_tag(d, c, 4), longint'(val4), exp);
    check(ob4 == ref_bad(d, c, 4), "R3", longint'(ob4), longint'(ref_bad(d, c, 4)));
    keep = val4; kb = ob4;
    d4 = 12'($urandom); c4 = 2'($urandom);
    @(negedge clk);
    check(ov4 == 1'b0, "R4", longint'(ov4), 0);
    check(val4 == keep && ob4 == kb, "R5", longint'(val4), longint'(keep));
  endtask

  task automatic run2(input logic [5:0] d, input logic [1:0] c);
    longint exp;
    logic signed [7:0] keep;
    logic kb;
    @(negedge clk); d2 = d; c2 = c; v2 = 1'b1;
    @(negedge clk); v2 = 1'b0;
    @(negedge clk);
    exp = ref_val({6'b0, d}, c, 2);
    check(ov2 == 1'b1, "R4", longint'(ov2), 1);
    check(val2 == exp[7:0], val_tag({6'b0, d}, c, 2), longint'(val2), exp);
    check(ob2 == ref_bad({6'b0, d}, c, 2), "R3", longint'(ob2),
          longint'(ref_bad({6'b0, d}, c, 2)));
    keep = val2; kb = ob2;
    d2 = 6'($urandom); c2 = 2'($urandom);
    @(negedge clk);
    check(ov2 == 1'b0, "R4", longint'(ov2), 0);
    check(val2 == keep && ob2 == kb, "R5", longint'(val2), longint'(keep));
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    // R6: outputs cleared while reset is held
    repeat (3) @(negedge clk);
    check(ov4 == 0 && ob4 == 0 && val4 == 0, "R6", longint'(val4), 0);
    check(ov2 == 0 && ob2 == 0 && val2 == 0, "R6", longint'(val2), 0);
    rst_n = 1'b1;

    // Directed corners on the 4-digit build
    run4(12'h000, 2'b00);                 // R1 zero
    run4(12'b011_011_011_011, 2'b01);      // R2 +511
    run4(12'b101_101_101_101, 2'b11);      // R2 -511
    run4(12'b000_000_000_001, 2'b00);      // R1 +1
    run4(12'b011_000_000_000, 2'b00);      // R1 +192
    run4(12'h000, 2'b01);                  // R2 +256
    run4(12'h000, 2'b11);                  // R2 -256
    run4(12'h000, 2'b10);                  // R3 carry illegal
    run4(12'b100_000_000_000, 2'b00);      // R3 digit illegal
    run4(12'b000_000_100_001, 2'b01);      // R3 low digit illegal

    // R7: back-to-back conversions
    @(negedge clk); d4 = 12'b001_111_010_101; c4 = 2'b01; v4 = 1'b1;
    @(negedge clk); d4 = 12'b110_011_000_111; c4 = 2'b11;
    @(negedge clk); v4 = 1'b0;
    check(ov4 == 1'b1 && longint'(val4) == ref_val(12'b001_111_010_101, 2'b01, 4),
          "R7", longint'(val4), ref_val(12'b001_111_010_101, 2'b01, 4));
    @(negedge clk);
    check(ov4 == 1'b1 && longint'(val4) == ref_val(12'b110_011_000_111, 2'b11, 4),
          "R7", longint'(val4), ref_val(12'b110_011_000_111, 2'b11, 4));
    @(negedge clk);
    check(ov4 == 1'b0, "R7", longint'(ov4), 0);

    // Exhaustive sweep of every field code on the 2-digit build
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 4; c++)
          run2({3'(b), 3'(a)}, 2'(c));

    // Random fields on the 4-digit build, mostly legal
    for (int k = 0; k < 300; k++) begin
      logic [11:0] rd;
      logic [1:0]  rc;
      for (int i = 0; i < 4; i++) begin
        int dv = int'($urandom_range(0, 6)) - 3;
        rd[3*i +: 3] = 3'(dv);
      end
      rc = 2'(int'($urandom_range(0, 2)) - 1);
      if ((k % 17) == 0) rd[3*(k % 4) +: 3] = 3'b100;
      if ((k % 23) == 0) rc = 2'b10;
      run4(rd, rc);
    end

    // R6: asynchronous reset after a nonzero result
    run4(12'b011_011_011_011, 2'b00);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check(ov4 == 0 && ob4 == 0 && val4 == 0, "R6", longint'(val4), 0);
    @(negedge clk); rst_n = 1'b1;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_mis++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end
endmodule